// File: doc/BRIEF.md
# Receive Modem Status and Interrupt Register

This block holds the status word that a host reads from a serial data modem receiver, and it raises the interrupt for that word. It latches receive events from the receiver datapath: a character arriving, a character lost because the holding register was full, a framing error, and the even-parity result of each held character. In two-character mode the block holds a pair of characters. It also tracks an external active-low ring input through a two-flop synchronizer. Seven more level flags come in from neighbouring detectors and appear in the word unchanged. In FSK operation the raw demodulator bit shows in bit 0.

The interrupt is edge-based. A 0-to-1 change of any status bit in positions 14..5 sets the sticky bit 15 if that bit is enabled in the control register. Bit 15 stays set until the host reads the status word or writes a clear or general-reset command. The active-low interrupt output has its own enable bit. Reading the receive data register returns the held characters and drops all receive flags.

Top module: `ms_stat_irq`

## Requirements
- R1: Status bit 15 is set one cycle after a 0-to-1 change of a status bit k in 5..13, provided its enable bit is 1. The enable is control bit k-5 for k<=9 and control bit k+1 for k>=10. A change with the enable at 0 leaves bit 15 at 0. Bits 13..7 mirror aux_flags_i[6:0].
- R2: A status read clears bit 15. If a qualifying edge happens in the same cycle as the read, bit 15 stays 1.
- R3: A control write with bit 7 or bit 8 at 1 clears bit 15.
- R4: irq_no is 0 exactly when status bit 15 is 1 and control bit 6 is 1.
- R5: Bit 6 (data ready) sets when a character is accepted and clears on a data register read. The first character appears on rxd_o[7:0].
- R6: Bit 5 (overflow) sets when a character arrives while the holding register is full. The register is full with one character in single mode and two in two-character mode. The newest character replaces the last slot. A data read clears bit 5.
- R7: Bit 14 equals the inverse of ring_ni, delayed two cycles, and keeps doing so while control bit 7 is 1.
- R8: The rise of bit 14 (ring_ni falling) sets bit 15 only when control bits 5 and 6 are both 1. A rising ring_ni never sets it.
- R9: With control bit 9 at 1 (two-character mode), bit 1 shows that two characters are held. Bit 3 and bit 2 are 1 when the first and second characters have an even count of ones. The second character appears on rxd_o[15:8].
- R10: Bit 0 equals demod_i when control bit 10 is 1 and reads 0 otherwise.
- R11: While control bit 7 is 1, status bits 6..1 and rxd_o are held at 0 and characters are dropped.
- R12: Bit 4 sets when a character arrives with rx_ferr_i high and clears on a data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 15 | Control register write data |
| rd_stat_i | input | 1 | Status register read strobe |
| rd_data_i | input | 1 | Receive data register read strobe |
| rx_stb_i | input | 1 | Received character valid |
| rx_char_i | input | 8 | Received character |
| rx_ferr_i | input | 1 | Framing error with the character |
| aux_flags_i | input | 7 | Level flags for status bits 13..7 |
| demod_i | input | 1 | Raw frequency demodulator bit |
| ring_ni | input | 1 | Ring input, active low, asynchronous |
| stat_o | output | 16 | Status word |
| rxd_o | output | 16 | Receive data register {second, first} |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench sweeps every edge-capable status bit with its enable on and off. A wrong enable map would raise or miss interrupts on exactly those bits. It places a status read in the same cycle as a fresh edge; a design that lets the read win would lose that event. All 256 character values are sent through two-character mode to check parity, and a third character is forced in, which catches overflow and slot-replacement errors. Ring edges are driven in both directions and under each enable combination, and during general reset. A design with a one-flop synchronizer, a level-triggered ring interrupt, or a ring bit frozen by reset would show a wrong bit 14 or bit 15.

// File: rtl/ms_pkg.sv
package ms_pkg;
  localparam int unsigned STAT_W = 16;
  localparam int unsigned CTRL_W = 15;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned AUX_W  = 7;

  localparam int unsigned B_IRQ   = 15;
  localparam int unsigned B_RING  = 14;
  localparam int unsigned B_AUX   = 7;
  localparam int unsigned B_RDY   = 6;
  localparam int unsigned B_OVF   = 5;
  localparam int unsigned B_FERR  = 4;
  localparam int unsigned B_PARA  = 3;
  localparam int unsigned B_PARB  = 2;
  localparam int unsigned B_DUAL  = 1;
  localparam int unsigned B_DEMOD = 0;

  localparam int unsigned EV_LO = 5;
  localparam int unsigned EV_HI = 14;
  localparam int unsigned EV_W  = EV_HI - EV_LO + 1;

  localparam int unsigned C_RING_EN = 5;
  localparam int unsigned C_IRQ_OE  = 6;
  localparam int unsigned C_GRST    = 7;
  localparam int unsigned C_CLR     = 8;
  localparam int unsigned C_DUAL    = 9;
  localparam int unsigned C_FSK     = 10;

  function automatic int unsigned mask_pos(int unsigned k);
    return (k <= 9) ? k - 5 : k + 1;
  endfunction
endpackage

// File: rtl/ms_ring_sync.sv
module ms_ring_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ring_ni,
  output logic ring_det_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= ring_ni;
      s2_q <= s1_q;
    end
  end

  assign ring_det_o = ~s2_q;
endmodule

// File: rtl/ms_rx_hold.sv
module ms_rx_hold
  import ms_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hold_clr_i,
  input  logic                dual_i,
  input  logic                stb_i,
  input  logic [CHAR_W-1:0]   char_i,
  input  logic                ferr_i,
  input  logic                rd_i,
  output logic                ready_o,
  output logic                ovf_o,
  output logic                ferr_o,
  output logic                par_a_o,
  output logic                par_b_o,
  output logic                two_o,
  output logic [2*CHAR_W-1:0] data_o
);
  logic [1:0]        cnt_q, cnt_n;
  logic [CHAR_W-1:0] a_q, a_n, b_q, b_n;
  logic              pa_q, pa_n, pb_q, pb_n, ovf_q, ovf_n, ferr_q, ferr_n;

  always_comb begin
    cnt_n  = cnt_q;
    a_n    = a_q;
    b_n    = b_q;
    pa_n   = pa_q;
    pb_n   = pb_q;
    ovf_n  = ovf_q;
    ferr_n = ferr_q;
    if (rd_i) begin
      cnt_n  = '0;
      a_n    = '0;
      b_n    = '0;
      pa_n   = 1'b0;
      pb_n   = 1'b0;
      ovf_n  = 1'b0;
      ferr_n = 1'b0;
    end
    if (stb_i) begin
      if (ferr_i) ferr_n = 1'b1;
      if (cnt_n == 2'd0) begin
        a_n   = char_i;
        pa_n  = ~^char_i;
        cnt_n = 2'd1;
      end else if (dual_i && cnt_n == 2'd1) begin
        b_n   = char_i;
        pb_n  = ~^char_i;
        cnt_n = 2'd2;
      end else begin
        ovf_n = 1'b1;
        if (dual_i) begin
          b_n  = char_i;
          pb_n = ~^char_i;
        end else begin
          a_n  = char_i;
          pa_n = ~^char_i;
        end
      end
    end
    if (hold_clr_i) begin
      cnt_n  = '0;
      a_n    = '0;
      b_n    = '0;
      pa_n   = 1'b0;
      pb_n   = 1'b0;
      ovf_n  = 1'b0;
      ferr_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      pa_q   <= 1'b0;
      pb_q   <= 1'b0;
      ovf_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      a_q    <= a_n;
      b_q    <= b_n;
      pa_q   <= pa_n;
      pb_q   <= pb_n;
      ovf_q  <= ovf_n;
      ferr_q <= ferr_n;
    end
  end

  assign ready_o = (cnt_q != 2'd0);
  assign two_o   = (cnt_q == 2'd2);
  assign ovf_o   = ovf_q;
  assign ferr_o  = ferr_q;
  assign par_a_o = pa_q;
  assign par_b_o = pb_q;
  assign data_o  = {b_q, a_q};
endmodule

// File: rtl/ms_irq_ctl.sv
module ms_irq_ctl
  import ms_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EV_W-1:0] ev_i,
  input  logic [EV_W-1:0] en_i,
  input  logic            rd_stat_i,
  input  logic            clr_cmd_i,
  output logic            edge_hit_o,
  output logic            irq_o
);
  logic [EV_W-1:0] prev_q;
  logic            irq_q;

  assign edge_hit_o = |(ev_i & ~prev_q & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= ev_i;
      // new edge outranks every clear source
      if (edge_hit_o)                  irq_q <= 1'b1;
      else if (rd_stat_i || clr_cmd_i) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ms_stat_irq.sv
module ms_stat_irq
  import ms_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_we_i,
  input  logic [CTRL_W-1:0]   ctrl_wdata_i,
  input  logic                rd_stat_i,
  input  logic                rd_data_i,
  input  logic                rx_stb_i,
  input  logic [CHAR_W-1:0]   rx_char_i,
  input  logic                rx_ferr_i,
  input  logic [AUX_W-1:0]    aux_flags_i,
  input  logic                demod_i,
  input  logic                ring_ni,
  output logic [STAT_W-1:0]   stat_o,
  output logic [2*CHAR_W-1:0] rxd_o,
  output logic                irq_no
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              ring_det, clr_cmd, edge_hit, irq;
  logic              ready, ovf, ferr, par_a, par_b, two;
  logic [EV_W-1:0]   ev_vec, en_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
  end

  assign clr_cmd = ctrl_we_i & (ctrl_wdata_i[C_GRST] | ctrl_wdata_i[C_CLR]);

  ms_ring_sync u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ring_ni    (ring_ni),
    .ring_det_o (ring_det)
  );

  ms_rx_hold u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_clr_i (ctrl_q[C_GRST]),
    .dual_i     (ctrl_q[C_DUAL]),
    .stb_i      (rx_stb_i),
    .char_i     (rx_char_i),
    .ferr_i     (rx_ferr_i),
    .rd_i       (rd_data_i),
    .ready_o    (ready),
    .ovf_o      (ovf),
    .ferr_o     (ferr),
    .par_a_o    (par_a),
    .par_b_o    (par_b),
    .two_o      (two),
    .data_o     (rxd_o)
  );

  assign ev_vec = {ring_det, aux_flags_i, ready, ovf};

  for (genvar k = EV_LO; k < EV_HI; k++) begin : g_en
    assign en_vec[k-EV_LO] = ctrl_q[mask_pos(k)];
  end
  assign en_vec[EV_HI-EV_LO] = ctrl_q[C_RING_EN] & ctrl_q[C_IRQ_OE];

  ms_irq_ctl u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev_vec),
    .en_i       (en_vec),
    .rd_stat_i  (rd_stat_i),
    .clr_cmd_i  (clr_cmd),
    .edge_hit_o (edge_hit),
    .irq_o      (irq)
  );

  always_comb begin
    stat_o                     = '0;
    stat_o[B_IRQ]              = irq;
    stat_o[EV_HI:EV_LO]        = ev_vec;
    stat_o[B_FERR]             = ferr;
    stat_o[B_PARA]             = par_a;
    stat_o[B_PARB]             = par_b;
    stat_o[B_DUAL]             = two;
    stat_o[B_DEMOD]            = ctrl_q[C_FSK] & demod_i;
  end

  assign irq_no = ~(irq & ctrl_q[C_IRQ_OE]);
endmodule

// File: rtl/ms_stat_irq_chk.sv
module ms_stat_irq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_stat_i,
  input logic        rd_data_i,
  input logic        rx_stb_i,
  input logic        edge_hit,
  input logic [15:0] stat_o,
  input logic [14:0] ctrl_q,
  input logic        irq_no
);
  a_r1_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[15]) |-> $past(edge_hit));

  a_r2_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !edge_hit) |=> !stat_o[15]);

  a_r4_pin_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == !(stat_o[15] && ctrl_q[6]));

  a_r5_read_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !rx_stb_i) |=> !stat_o[6]);

  a_r6_overflow_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[5]) |-> $past(rx_stb_i));

  a_r10_qam_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[10] |-> !stat_o[0]);

  a_r11_hold_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[7] && $past(ctrl_q[7])) |-> (stat_o[6:1] == 6'd0));
endmodule

bind ms_stat_irq ms_stat_irq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_stat_i (rd_stat_i),
  .rd_data_i (rd_data_i),
  .rx_stb_i  (rx_stb_i),
  .edge_hit  (edge_hit),
  .stat_o    (stat_o),
  .ctrl_q    (ctrl_q),
  .irq_no    (irq_no)
);

// File: tb/tb_ms_stat_irq.sv
module tb_ms_stat_irq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [14:0] ctrl_wdata = '0;
  logic        rd_stat = 1'b0, rd_data = 1'b0, rx_stb = 1'b0, rx_ferr = 1'b0;
  logic [7:0]  rx_char = '0;
  logic [6:0]  aux = '0;
  logic        demod = 1'b0, ring_n = 1'b1;
  logic [15:0] stat, rxd;
  logic        irq_n;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ms_stat_irq dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .rd_stat_i(rd_stat), .rd_data_i(rd_data), .rx_stb_i(rx_stb), .rx_char_i(rx_char),
    .rx_ferr_i(rx_ferr), .aux_flags_i(aux), .demod_i(demod), .ring_ni(ring_n),
    .stat_o(stat), .rxd_o(rxd), .irq_no(irq_n)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wctrl(logic [14:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v; tick(1); ctrl_we = 1'b0;
  endtask

  task automatic rdstat();
    rd_stat = 1'b1; tick(1); rd_stat = 1'b0;
  endtask

  task automatic rddata();
    rd_data = 1'b1; tick(1); rd_data = 1'b0;
  endtask

  task automatic send(logic [7:0] c, logic fe);
    rx_stb = 1'b1; rx_char = c; rx_ferr = fe; tick(1);
    rx_stb = 1'b0; rx_ferr = 1'b0;
  endtask

  function automatic int mpos(int k);
    return (k <= 9) ? k - 5 : k + 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    // reset state
    chk("R10 reset stat", stat, 16'h0000);
    chk("R5 reset rxd", rxd, 16'h0000);
    chk("R4 reset pin", {15'd0, irq_n}, 16'd1);

    // R5 ready / data read
    send(8'hA5, 1'b0);
    chk("R5 ready set", {15'd0, stat[6]}, 16'd1);
    chk("R5 data", rxd, 16'h00A5);
    rddata();
    chk("R5 ready clear", {15'd0, stat[6]}, 16'd0);

    // R12 framing
    send(8'h3C, 1'b1);
    chk("R12 ferr set", {15'd0, stat[4]}, 16'd1);
    rddata();
    chk("R12 ferr clear", {15'd0, stat[4]}, 16'd0);

    // R6 single-mode overflow
    send(8'h11, 1'b0);
    send(8'h22, 1'b0);
    chk("R6 ovf set", {15'd0, stat[5]}, 16'd1);
    chk("R6 newest kept", rxd, 16'h0022);
    rddata();
    chk("R6 ovf clear", {15'd0, stat[5]}, 16'd0);

    // R9 two-character sweep over all codes
    wctrl(15'h0200);
    for (int c = 0; c < 256; c++) begin
      logic [7:0] c1, c2, c3;
      c1 = c[7:0]; c2 = c1 ^ 8'h5A; c3 = ~c1;
      send(c1, 1'b0);
      chk("R9 one held", {15'd0, stat[1]}, 16'd0);
      send(c2, 1'b0);
      chk("R9 two held", {15'd0, stat[1]}, 16'd1);
      chk("R9 parity first", {15'd0, stat[3]}, {15'd0, ~^c1});
      chk("R9 parity second", {15'd0, stat[2]}, {15'd0, ~^c2});
      chk("R9 pair", rxd, {c2, c1});
      chk("R6 no early ovf", {15'd0, stat[5]}, 16'd0);
      send(c3, 1'b0);
      chk("R6 dual ovf", {15'd0, stat[5]}, 16'd1);
      chk("R6 dual replace", rxd, {c3, c1});
      rddata();
      chk("R9 clear", stat & 16'h007E, 16'h0000);
    end

    // R1 / R4 enable sweep over bits 5..13
    for (int k = 5; k <= 13; k++) begin
      for (int on = 0; on < 2; on++) begin
        logic [14:0] cv;
        cv = 15'h0040;
        if (on == 1) cv[mpos(k)] = 1'b1;
        wctrl(cv);
        rdstat();
        if (k == 5) begin send(8'h01, 1'b0); send(8'h02, 1'b0); end
        else if (k == 6) send(8'h03, 1'b0);
        else aux[k-7] = 1'b1;
        tick(2);
        chk("R1 masked edge", {15'd0, stat[15]}, on[15:0]);
        chk("R4 pin", {15'd0, irq_n}, {15'd0, ~on[0]});
        aux = '0;
        rddata();
        rdstat();
        tick(1);
      end
    end

    // R2 read clears, same-cycle edge wins
    wctrl(15'h0040 | 15'h0004);
    rdstat();
    aux[0] = 1'b1; tick(2);
    chk("R2 set", {15'd0, stat[15]}, 16'd1);
    rdstat();
    chk("R2 read clears", {15'd0, stat[15]}, 16'd0);
    aux[0] = 1'b0; tick(2);
    rd_stat = 1'b1; aux[0] = 1'b1; tick(1); rd_stat = 1'b0;
    chk("R2 edge wins", {15'd0, stat[15]}, 16'd1);
    aux[0] = 1'b0;

    // R4 output enable off
    wctrl(15'h0004);
    chk("R4 oe off", {15'd0, irq_n}, 16'd1);
    chk("R4 irq kept", {15'd0, stat[15]}, 16'd1);

    // R3 clear command bit 8
    wctrl(15'h0044 | 15'h0100);
    chk("R3 bit8 clears", {15'd0, stat[15]}, 16'd0);
    wctrl(15'h0044);
    aux[0] = 1'b1; tick(2);
    chk("R3 re-set", {15'd0, stat[15]}, 16'd1);
    aux[0] = 1'b0;
    send(8'h77, 1'b0);
    // R3 / R11 general reset bit 7
    wctrl(15'h0044 | 15'h0080);
    chk("R3 bit7 clears", {15'd0, stat[15]}, 16'd0);
    tick(1);
    chk("R11 ready dropped", {15'd0, stat[6]}, 16'd0);
    send(8'h55, 1'b0);
    tick(1);
    chk("R11 char ignored", stat & 16'h007E, 16'h0000);
    chk("R11 rxd held", rxd, 16'h0000);
    ring_n = 1'b0; tick(1);
    chk("R7 one-cycle lag", {15'd0, stat[14]}, 16'd0);
    tick(1);
    chk("R7 ring in reset", {15'd0, stat[14]}, 16'd1);
    ring_n = 1'b1; tick(3);
    chk("R7 ring release", {15'd0, stat[14]}, 16'd0);
    wctrl(15'h0000);
    rdstat();

    // R8 ring interrupt gating
    wctrl(15'h0020);
    ring_n = 1'b0; tick(4);
    chk("R8 no oe", {15'd0, stat[15]}, 16'd0);
    ring_n = 1'b1; tick(4);
    wctrl(15'h0040);
    ring_n = 1'b0; tick(4);
    chk("R8 no ring en", {15'd0, stat[15]}, 16'd0);
    ring_n = 1'b1; tick(4);
    wctrl(15'h0060);
    ring_n = 1'b0; tick(4);
    chk("R8 fall sets", {15'd0, stat[15]}, 16'd1);
    chk("R8 pin low", {15'd0, irq_n}, 16'd0);
    rdstat();
    ring_n = 1'b1; tick(4);
    chk("R8 rise ignored", {15'd0, stat[15]}, 16'd0);

    // R10 demodulator bit
    demod = 1'b1; tick(1);
    chk("R10 qam zero", {15'd0, stat[0]}, 16'd0);
    wctrl(15'h0400);
    chk("R10 fsk one", {15'd0, stat[0]}, 16'd1);
    demod = 1'b0; tick(1);
    chk("R10 fsk zero", {15'd0, stat[0]}, 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule